// File: doc/BRIEF.md
# Stack Logic, Compare and Branch Unit

This unit executes the non-arithmetic word-level operations of a 48-bit zero-address machine. Every operand it consumes is read from the top of a stack that lives in ordinary word memory, and every result it produces is written back onto that stack. A stack pointer held inside the unit marks the first free slot. The top word sits one address below it, and the stack grows toward higher addresses. The unit handles the bitwise operations, the signed relational compares, the stack shuffles (exchange, duplicate, delete), two store variants and relative jumps. Jumps come as forward or backward and as conditional or unconditional.

An operation code arrives on a valid/ready stream of one code per beat. The sender holds `op_valid` and `op_code` steady until `op_ready` is high at a clock edge. `op_ready` stays low from acceptance until the cycle after `done`, which applies back-pressure for as long as the operation lasts. The memory port has no back-pressure. A read issued in one cycle returns its data on `mem_rdata` in the next cycle, and a write completes at the edge where it is issued. Jumps never touch the program counter directly: the unit emits a one-cycle update request with a 10-bit distance and a direction. A neighbouring unit that pushes literals or operands may reposition the pointer through `sp_set` while the unit is idle.

Top module: `stkop_unit`

## Requirements
- R1: `op_ready` is high only when the unit is idle. A code is taken at an edge where `op_valid` and `op_ready` are both high. `done` is high for exactly one cycle when the operation ends, and `op_ready` returns in the following cycle. The memory port stays quiet while `op_ready` is high.
- R2: Codes 0 (AND), 1 (OR) and 2 (equivalence: 1 wherever the two bits match) combine the word below the top with the top word, bit by bit. They remove both words and push the single result, so the pointer drops by one.
- R3: Code 3 replaces the top word with its bitwise complement and leaves the pointer unchanged.
- R4: Codes 4 to 9 compare the lower word L against the top word T as signed two's complement numbers. The tests are L==T, L!=T, L<T, L<=T, L>T and L>=T, in that order. Both words are removed and one word is pushed: all ones for true, zero for false.
- R5: Code 10 swaps the top two words. Code 11 pushes a copy of the top word. Code 12 discards the top word.
- R6: Codes 13 and 14 treat the top word as an address (its low 15 bits) and the word below it as the value, and write the value to that address. Code 13 pops both words. Code 14 pops only the address, so the value stays on top.
- R7: Codes 15 and 16 are unconditional jumps, forward and backward. Codes 17 and 18 are conditional jumps, forward and backward, whose condition is the word below the top. For a taken jump, `pc_upd` pulses once with `pc_off` equal to the low 10 bits of the top word and `pc_back` high for backward codes. A conditional jump is taken only when its condition is nonzero. Every jump pops the offset, and a conditional jump also pops the condition.
- R8: After reset the pointer equals `STK_BASE`. A push raises the pointer by one and a pop lowers it by one. `sp_set` loads `sp_set_val` when the unit is idle and no code is offered. `sp_o` changes only in a `done` cycle or in the cycle after such a load.
- R9: An operation that would pop more words than the stack holds, or would leave more than `STK_DEPTH` words on it, is aborted. `done` comes in the cycle after acceptance, with no memory access and no pointer change. `stk_err` is set and stays high until reset.
- R10: Codes 19 to 31 do nothing. They raise `done`, leave the pointer and memory untouched, and do not pulse `pc_upd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation code offered |
| op_ready | output | 1 | Unit idle and able to take a code |
| op_code | input | 5 | Operation code |
| sp_set | input | 1 | Load the stack pointer (idle only) |
| sp_set_val | input | AW | Value loaded by `sp_set` |
| sp_o | output | AW | Current stack pointer (first free slot) |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, one cycle after the read |
| pc_upd | output | 1 | Program counter update request |
| pc_back | output | 1 | Update moves backward |
| pc_off | output | OW | Jump distance in words |
| done | output | 1 | Operation finished (one cycle) |
| stk_err | output | 1 | Sticky stack bound violation |

## Verification
Most internal faults in this unit reach the ports within one operation. The result slot in memory and `sp_o` are both settled by the `done` cycle. A wrong top or lower operand register shows up there as a wrong result word. A wrong pointer adjustment shows up as a `sp_o` value off by one or two. A wrong depth check shows up as `stk_err` rising, or failing to rise, at the `done` that follows acceptance. A wrong jump decision is visible one cycle before `done`, as a `pc_upd` pulse that is missing or extra, or that carries the wrong distance or direction.

// File: rtl/stkop_pkg.sv
package stkop_pkg;

  typedef enum logic [4:0] {
    OP_AND = 5'd0,  OP_OR  = 5'd1,  OP_EQV = 5'd2,  OP_NOT = 5'd3,
    OP_CEQ = 5'd4,  OP_CNE = 5'd5,  OP_CLT = 5'd6,  OP_CLE = 5'd7,
    OP_CGT = 5'd8,  OP_CGE = 5'd9,  OP_XCH = 5'd10, OP_DUP = 5'd11,
    OP_DEL = 5'd12, OP_STO = 5'd13, OP_STK = 5'd14, OP_JFU = 5'd15,
    OP_JBU = 5'd16, OP_JFC = 5'd17, OP_JBC = 5'd18
  } stk_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RD0, S_RD1, S_RD2, S_WR0, S_WR1, S_FIN
  } stk_st_e;

  // words removed from and then placed onto the stack by one operation
  typedef struct packed {
    logic [1:0] pops;
    logic [1:0] pushes;
  } stk_use_t;

  function automatic stk_use_t op_use(input logic [4:0] code);
    stk_use_t u;
    case (code)
      OP_AND, OP_OR, OP_EQV,
      OP_CEQ, OP_CNE, OP_CLT, OP_CLE, OP_CGT, OP_CGE: u = '{2'd2, 2'd1};
      OP_NOT:                                          u = '{2'd1, 2'd1};
      OP_XCH:                                          u = '{2'd2, 2'd2};
      OP_DUP:                                          u = '{2'd1, 2'd2};
      OP_DEL, OP_JFU, OP_JBU:                          u = '{2'd1, 2'd0};
      OP_STO, OP_JFC, OP_JBC:                          u = '{2'd2, 2'd0};
      OP_STK:                                          u = '{2'd2, 2'd1};
      default:                                         u = '{2'd0, 2'd0};
    endcase
    return u;
  endfunction

  function automatic logic is_jump(input logic [4:0] code);
    return (code == OP_JFU) || (code == OP_JBU) || (code == OP_JFC) || (code == OP_JBC);
  endfunction

endpackage

// File: rtl/stkop_alu.sv
module stkop_alu
  import stkop_pkg::*;
#(
  parameter int DW = 48
) (
  input  logic [4:0]    code,
  input  logic [DW-1:0] top,
  input  logic [DW-1:0] nxt,
  output logic [DW-1:0] res,
  output logic          take
);
  logic eq, lt, truth;

  assign eq = (nxt == top);
  assign lt = ($signed(nxt) < $signed(top));

  always_comb begin
    case (code)
      OP_CEQ:  truth = eq;
      OP_CNE:  truth = !eq;
      OP_CLT:  truth = lt;
      OP_CLE:  truth = lt || eq;
      OP_CGT:  truth = !(lt || eq);
      OP_CGE:  truth = !lt;
      default: truth = 1'b0;
    endcase
  end

  always_comb begin
    case (code)
      OP_AND:  res = nxt & top;
      OP_OR:   res = nxt | top;
      OP_EQV:  res = ~(nxt ^ top);
      OP_NOT:  res = ~top;
      default: res = {DW{truth}};
    endcase
  end

  assign take = ((code == OP_JFC) || (code == OP_JBC)) ? (nxt != '0) : 1'b1;
endmodule

// File: rtl/stkop_ptr.sv
module stkop_ptr
  import stkop_pkg::*;
#(
  parameter int AW        = 15,
  parameter int STK_BASE  = 16384,
  parameter int STK_DEPTH = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          commit,
  input  stk_use_t      chk_use,
  input  stk_use_t      cmt_use,
  output logic [AW-1:0] sp,
  output logic          bound_err
);
  localparam logic [AW:0]   BASE_X  = (AW+1)'(STK_BASE);
  localparam logic [AW:0]   DEPTH_X = (AW+1)'(STK_DEPTH);
  localparam logic [AW-1:0] BASE_A  = AW'(STK_BASE);

  logic [AW:0] dep, pop_x, push_x;

  assign dep    = {1'b0, sp} - BASE_X;
  assign pop_x  = {{(AW-1){1'b0}}, chk_use.pops};
  assign push_x = {{(AW-1){1'b0}}, chk_use.pushes};
  assign bound_err = (dep < pop_x) || ((dep - pop_x + push_x) > DEPTH_X);

  always_ff @(posedge clk) begin
    if (!rst_n)      sp <= BASE_A;
    else if (load)   sp <= load_val;
    else if (commit) sp <= sp - {{(AW-2){1'b0}}, cmt_use.pops}
                              + {{(AW-2){1'b0}}, cmt_use.pushes};
  end
endmodule

// File: rtl/stkop_unit.sv
module stkop_unit
  import stkop_pkg::*;
#(
  parameter int DW        = 48,
  parameter int AW        = 15,
  parameter int OW        = 10,
  parameter int STK_BASE  = 16384,
  parameter int STK_DEPTH = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic [4:0]    op_code,
  input  logic          sp_set,
  input  logic [AW-1:0] sp_set_val,
  output logic [AW-1:0] sp_o,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          pc_upd,
  output logic          pc_back,
  output logic [OW-1:0] pc_off,
  output logic          done,
  output logic          stk_err
);
  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [AW-1:0] TWO = AW'(2);

  stk_st_e       st;
  logic [4:0]    op_q;
  stk_use_t      use_q, use_in;
  logic [DW-1:0] top_q, nxt_q, alu_res;
  logic          alu_take, bound_err, accept, jmp;

  assign use_in = op_use(op_code);
  assign accept = op_valid && op_ready;
  assign jmp    = is_jump(op_q);

  stkop_ptr #(.AW(AW), .STK_BASE(STK_BASE), .STK_DEPTH(STK_DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .load(sp_set && (st == S_IDLE) && !op_valid), .load_val(sp_set_val),
    .commit(st == S_WR0), .chk_use(use_in), .cmt_use(use_q),
    .sp(sp_o), .bound_err(bound_err)
  );

  stkop_alu #(.DW(DW)) u_alu (
    .code(op_q), .top(top_q), .nxt(nxt_q), .res(alu_res), .take(alu_take)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op_q    <= '0;
      use_q   <= '0;
      top_q   <= '0;
      nxt_q   <= '0;
      stk_err <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          op_q  <= op_code;
          use_q <= use_in;
          if (bound_err) begin
            stk_err <= 1'b1;
            st      <= S_FIN;
          end else if (use_in.pops == 2'd0) begin
            st <= S_FIN;
          end else begin
            st <= S_RD0;
          end
        end
        S_RD0: st <= S_RD1;
        S_RD1: begin
          top_q <= mem_rdata;
          st    <= (use_q.pops == 2'd2) ? S_RD2 : S_WR0;
        end
        S_RD2: begin
          nxt_q <= mem_rdata;
          st    <= S_WR0;
        end
        S_WR0:   st <= (op_q == OP_XCH) ? S_WR1 : S_FIN;
        S_WR1:   st <= S_FIN;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      S_RD0: begin
        mem_req  = 1'b1;
        mem_addr = sp_o - ONE;
      end
      S_RD1: if (use_q.pops == 2'd2) begin
        mem_req  = 1'b1;
        mem_addr = sp_o - TWO;
      end
      S_WR0: case (op_q)
        OP_AND, OP_OR, OP_EQV, OP_CEQ, OP_CNE,
        OP_CLT, OP_CLE, OP_CGT, OP_CGE: begin
          mem_req = 1'b1; mem_we = 1'b1; mem_addr = sp_o - TWO; mem_wdata = alu_res;
        end
        OP_NOT: begin
          mem_req = 1'b1; mem_we = 1'b1; mem_addr = sp_o - ONE; mem_wdata = alu_res;
        end
        OP_XCH: begin
          mem_req = 1'b1; mem_we = 1'b1; mem_addr = sp_o - TWO; mem_wdata = top_q;
        end
        OP_DUP: begin
          mem_req = 1'b1; mem_we = 1'b1; mem_addr = sp_o; mem_wdata = top_q;
        end
        OP_STO, OP_STK: begin
          mem_req = 1'b1; mem_we = 1'b1; mem_addr = top_q[AW-1:0]; mem_wdata = nxt_q;
        end
        default: ;
      endcase
      S_WR1: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = sp_o - ONE; mem_wdata = nxt_q;
      end
      default: ;
    endcase
  end

  assign op_ready = (st == S_IDLE);
  assign done     = (st == S_FIN);
  assign pc_upd   = (st == S_WR0) && jmp && alu_take;
  assign pc_back  = (op_q == OP_JBU) || (op_q == OP_JBC);
  assign pc_off   = top_q[OW-1:0];
endmodule

// File: rtl/stkop_chk.sv
module stkop_chk #(
  parameter int AW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_ready,
  input logic          done,
  input logic          mem_req,
  input logic          mem_we,
  input logic          pc_upd,
  input logic          stk_err,
  input logic [AW-1:0] sp_o
);
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready |-> !mem_req); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && op_ready)); // R1
  AST_WRITE_IS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req); // R6
  AST_JUMP_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_upd |=> done); // R7
  AST_SP_MOVES_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_o != $past(sp_o)) |-> (done || $past(op_ready))); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stk_err |=> stk_err); // R9
  AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stk_err) |-> (done && !mem_req && $stable(sp_o))); // R9
endmodule

bind stkop_unit stkop_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_ready(op_ready), .done(done),
  .mem_req(mem_req), .mem_we(mem_we), .pc_upd(pc_upd),
  .stk_err(stk_err), .sp_o(sp_o)
);

// File: tb/stkop_unit_tb.sv
module stkop_unit_tb;
  localparam int DW = 48, AW = 15, OW = 10;
  localparam int BASE = 16, DEPTH = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0, sp_set = 1'b0;
  logic [4:0] op_code = '0;
  logic [AW-1:0] sp_set_val = '0;
  logic op_ready, mem_req, mem_we, pc_upd, pc_back, done, stk_err;
  logic [AW-1:0] sp_o, mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [OW-1:0] pc_off;

  logic [DW-1:0] mem [0:(1<<AW)-1];
  int total = 0, bad = 0, cyc = 0;
  logic pc_seen, pcb_s, busy_seen, done_after;
  logic [OW-1:0] pco_s;

  always #5 clk = ~clk;

  stkop_unit #(.DW(DW), .AW(AW), .OW(OW), .STK_BASE(BASE), .STK_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .sp_set(sp_set), .sp_set_val(sp_set_val), .sp_o(sp_o),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pc_upd(pc_upd),
    .pc_back(pc_back), .pc_off(pc_off), .done(done), .stk_err(stk_err)
  );

  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_sp(input int v);
    @(negedge clk); sp_set = 1'b1; sp_set_val = AW'(v);
    @(negedge clk); sp_set = 1'b0;
  endtask

  task automatic run(input logic [4:0] code);
    int n = 0;
    @(negedge clk);
    while (!op_ready) @(negedge clk);
    op_valid = 1'b1; op_code = code;
    @(negedge clk); op_valid = 1'b0;
    busy_seen = !op_ready;
    pc_seen = 1'b0; pco_s = '0; pcb_s = 1'b0;
    while (!done && n < 50) begin
      if (pc_upd) begin pc_seen = 1'b1; pco_s = pc_off; pcb_s = pc_back; end
      @(negedge clk); n++;
    end
    if (n >= 50) chk("R1 done timeout", 0, 1);
    @(negedge clk);
    done_after = done;
  endtask

  task automatic load2(input logic [DW-1:0] lo, input logic [DW-1:0] hi);
    mem[BASE] = lo; mem[BASE+1] = hi;
    set_sp(BASE + 2);
  endtask

  function automatic logic [DW-1:0] exp_bin(input int c, input logic [DW-1:0] l, input logic [DW-1:0] t);
    logic r;
    case (c)
      0: return l & t;
      1: return l | t;
      2: return ~(l ^ t);
      4: r = ($signed(l) == $signed(t));
      5: r = ($signed(l) != $signed(t));
      6: r = ($signed(l) <  $signed(t));
      7: r = ($signed(l) <= $signed(t));
      8: r = ($signed(l) >  $signed(t));
      default: r = ($signed(l) >= $signed(t));
    endcase
    return r ? {DW{1'b1}} : '0;
  endfunction

  logic [DW-1:0] pat [0:5];

  initial begin
    for (int i = 0; i < (1<<AW); i++) mem[i] = '0;
    pat[0] = '0; pat[1] = 48'd1; pat[2] = {DW{1'b1}};
    pat[3] = 48'h7FFF_FFFF_FFFF; pat[4] = 48'h8000_0000_0000; pat[5] = 48'h1234_5678_9ABC;

    do_reset();
    chk("R8 reset sp", sp_o, BASE);
    chk("R9 reset err", stk_err, 0);
    chk("R1 reset ready", op_ready, 1);

    // R2 / R4 sweep over operand pairs
    for (int c = 0; c < 10; c++) begin
      if (c == 3) continue;
      for (int a = 0; a < 6; a++)
        for (int b = 0; b < 6; b++) begin
          load2(pat[a], pat[b]);
          run(5'(c));
          chk(c < 3 ? "R2 logic result" : "R4 compare result", mem[BASE], exp_bin(c, pat[a], pat[b]));
          chk(c < 3 ? "R2 sp" : "R4 sp", sp_o, BASE + 1);
        end
    end
    chk("R1 busy during op", busy_seen, 1);
    chk("R1 done one cycle", done_after, 0);

    // R3 complement
    for (int a = 0; a < 6; a++) begin
      mem[BASE] = pat[a]; set_sp(BASE + 1);
      run(5'd3);
      chk("R3 not result", mem[BASE], ~pat[a]);
      chk("R3 sp", sp_o, BASE + 1);
    end

    // R5 exchange, duplicate, delete
    load2(pat[5], pat[4]); run(5'd10);
    chk("R5 xch low", mem[BASE], pat[4]);
    chk("R5 xch top", mem[BASE+1], pat[5]);
    chk("R5 xch sp", sp_o, BASE + 2);
    mem[BASE+2] = '0; run(5'd11);
    chk("R5 dup copy", mem[BASE+2], pat[5]);
    chk("R5 dup sp", sp_o, BASE + 3);
    run(5'd12);
    chk("R5 del sp", sp_o, BASE + 2);
    chk("R5 del keeps below", mem[BASE+1], pat[5]);

    // R6 stores
    load2(pat[5], 48'h0000_0000_0200); run(5'd13);
    chk("R6 store value", mem[15'h200], pat[5]);
    chk("R6 store sp", sp_o, BASE);
    load2(pat[3], 48'hFFFF_FFFF_8201); run(5'd14);
    chk("R6 keep-store value", mem[15'h201], pat[3]);
    chk("R6 keep-store sp", sp_o, BASE + 1);
    chk("R6 keep-store value on top", mem[BASE], pat[3]);

    // R7 jumps
    for (int j = 15; j <= 18; j++)
      for (int cnd = 0; cnd < 2; cnd++)
        for (int o = 0; o < 2; o++) begin
          logic [DW-1:0] off;
          logic cond_j, tk;
          off = (o == 0) ? 48'd1023 : 48'h0000_0000_1C05;
          cond_j = (j >= 17);
          if (cond_j) load2(cnd ? 48'd5 : 48'd0, off);
          else begin mem[BASE] = off; set_sp(BASE + 1); end
          run(5'(j));
          tk = cond_j ? (cnd == 1) : 1'b1;
          chk("R7 taken", pc_seen, tk);
          if (tk) begin
            chk("R7 offset", pco_s, off[OW-1:0]);
            chk("R7 direction", pcb_s, (j == 16 || j == 18));
          end
          chk("R7 pops", sp_o, BASE);
        end

    // R10 undefined code
    load2(pat[1], pat[2]); run(5'd25);
    chk("R10 sp unchanged", sp_o, BASE + 2);
    chk("R10 no pc", pc_seen, 0);
    chk("R10 mem unchanged", mem[BASE+1], pat[2]);
    chk("R10 no error", stk_err, 0);

    // R9 bounds
    set_sp(BASE + DEPTH - 1); run(5'd11);
    chk("R9 dup to limit ok", stk_err, 0);
    chk("R9 dup to limit sp", sp_o, BASE + DEPTH);
    mem[BASE+DEPTH] = 48'hABCD; run(5'd11);
    chk("R9 overflow err", stk_err, 1);
    chk("R9 overflow sp", sp_o, BASE + DEPTH);
    chk("R9 overflow no write", mem[BASE+DEPTH], 48'hABCD);
    set_sp(BASE + 2); run(5'd12);
    chk("R9 sticky", stk_err, 1);
    do_reset();
    chk("R9 cleared by reset", stk_err, 0);
    mem[BASE] = 48'h55; set_sp(BASE + 1); run(5'd0);
    chk("R9 underflow err", stk_err, 1);
    chk("R9 underflow sp", sp_o, BASE + 1);
    chk("R9 underflow mem", mem[BASE], 48'h55);
    do_reset();
    run(5'd12);
    chk("R9 empty delete err", stk_err, 1);
    chk("R8 empty sp", sp_o, BASE);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule